// File: doc/BRIEF.md
# Serial Control Register Port

This block is a single-line serial control port with the register file behind it. A host sends 16-bit frames on `ser_i`. The line idles high. A frame opens with a zero start bit, followed by twelve data bits and a three-bit register address, all most significant bit first. The port samples the line only on master-clock edges where the word qualifier `word_en_i` is high. A qualified sample of one after the last address bit acts as the stop bit and commits the frame. Without it the frame is dropped.

The read/write select is taken once, at the start-bit sample. A write updates the addressed register. A read leaves every register untouched and returns the addressed register on `ser_o` as a zero start bit followed by twelve data bits, one bit per qualified edge.

The register file drives the programmable settings of a line front end: receive gain, receive attenuator, transmit attenuation, a configuration word, an 8-bit oscillator tuning code, a tone threshold and a set of sticky status flags. The status flags are raised by event inputs and cleared by writing zero. All traffic is ignored while `suspend_i` is high.

Top module: `scif_ctrl`

## Requirements
- R1: The line is sampled only on rising clock edges with `word_en_i` high. A qualified sample of 1 while idle is ignored, and a qualified 0 while idle opens a frame.
- R2: After the start bit, the next 15 qualified samples are frame bits 14 down to 0. Bits 14..3 are data, MSB first, and bits 2..0 are the register address. A write changes only the addressed register.
- R3: `rd_nwr_i` is sampled only with the start bit: 0 selects write and 1 selects read. Its level during later bits has no effect.
- R4: The qualified sample after bit 0 must be 1 (stop). If it is 0 the frame is discarded and no register changes.
- R5: On a committed read, `ser_o` drives 0 after the stop edge, then data bits 11..0 after each following qualified edge, then returns high. A read changes no register.
- R6: While `suspend_i` is high, frames are ignored, a frame in progress is abandoned, and no register changes.
- R7: Address 0 holds receive gain in data[4:0] (0..31) on `rx_gain_o` and the attenuator setting in data[6:5] (0..3) on `rx_atten_o`. Readback bits 11..7 are 0.
- R8: Address 1 holds transmit attenuation in data[3:0] (0..15) on `tx_atten_o`. Readback bits 11..4 are 0.
- R9: Address 2 (configuration, `cfg_o`) and address 6 (tone threshold, `tone_thr_o`) hold all 12 bits. Addresses 4 and 5 are 12-bit scratch registers that are readable only through the port.
- R10: Address 3 drives data[7:0] on `osc_dac_o`. Readback bits 11..8 are 0.
- R11: Address 7 holds the status flags in bits 3..0. A high `status_set_i[i]` at a clock edge sets flag i. Writing 0 to a flag clears it, writing 1 leaves it unchanged, and a set in the same cycle wins over a clear. Readback bits 11..4 are 0.
- R12: `rst_ni` low asynchronously clears every register, sets `ser_o` high and returns the receiver to idle.
- R13: A write is visible on the outputs right after the qualified edge that samples its stop bit, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| suspend_i | input | 1 | High blocks all register access |
| word_en_i | input | 1 | Sample qualifier (word clock) |
| ser_i | input | 1 | Serial frame input, idles high |
| rd_nwr_i | input | 1 | Read (1) / write (0) select, sampled with start bit |
| status_set_i | input | 4 | Per-flag status set events |
| ser_o | output | 1 | Serial read response, idles high |
| rx_gain_o | output | 5 | Receive gain code |
| rx_atten_o | output | 2 | Receive attenuator setting |
| tx_atten_o | output | 4 | Transmit attenuation code |
| cfg_o | output | 12 | Configuration word |
| osc_dac_o | output | 8 | Oscillator tuning DAC code |
| tone_thr_o | output | 12 | Tone detection threshold |
| status_o | output | 4 | Sticky status flags |

## Verification
The bench builds the port with its default widths: 12 data bits, four status flags and an 8-bit DAC field. At these widths every receive gain and attenuator pair (128 combinations) and every transmit code (16) can be written and checked. All eight addresses can be read back bit by bit against a model kept in the bench. The same configuration also reaches the timing corners: the output update at the stop edge, a missing stop bit, a frame sent under suspend, set winning over clear in the status flags, and a reset asserted between clock edges.

// File: rtl/scif_pkg.sv
package scif_pkg;
  localparam int ADDR_W = 3;
  localparam int RXG_W  = 5;
  localparam int RXA_W  = 2;
  localparam int TXA_W  = 4;

  localparam logic [ADDR_W-1:0] A_RXG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TXA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DAC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TST0 = 3'd4;
  localparam logic [ADDR_W-1:0] A_TST1 = 3'd5;
  localparam logic [ADDR_W-1:0] A_THR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STOP} rx_state_e;
endpackage

// File: rtl/scif_rx.sv
module scif_rx
  import scif_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_i,
  input  logic              word_en_i,
  input  logic              ser_i,
  input  logic              rd_nwr_i,
  output logic              commit_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int BODY_W = DATA_W + ADDR_W;
  localparam int CNT_W  = $clog2(BODY_W + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BODY_W-1:0] sh_q;
  logic              rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
    end else if (suspend_i) begin
      state_q <= ST_IDLE;
    end else if (word_en_i) begin
      case (state_q)
        ST_IDLE: if (!ser_i) begin
          state_q <= ST_SHIFT;
          cnt_q   <= CNT_W'(BODY_W);
          rw_q    <= rd_nwr_i;
        end
        ST_SHIFT: begin
          sh_q  <= {sh_q[BODY_W-2:0], ser_i};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_STOP;
        end
        default: state_q <= ST_IDLE;  // stop sample, valid or not
      endcase
    end
  end

  assign commit_o = (state_q == ST_STOP) && word_en_i && ser_i && !suspend_i;
  assign rd_o     = rw_q;
  assign addr_o   = sh_q[ADDR_W-1:0];
  assign data_o   = sh_q[BODY_W-1:ADDR_W];

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && word_en_i && ser_i) |=> state_q == ST_IDLE);
  // R1
  shift_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> (cnt_q != '0 && cnt_q <= CNT_W'(BODY_W)));
endmodule

// File: rtl/scif_tx.sv
module scif_tx #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o
);
  localparam int SH_W  = DATA_W + 1;
  localparam int CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= {1'b0, data_i};
      cnt_q <= CNT_W'(SH_W);
    end else if (word_en_i && cnt_q != '0) begin
      sh_q  <= {sh_q[SH_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ser_o = (cnt_q != '0) ? sh_q[SH_W-1] : 1'b1;

  // R5
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_en_i && !load_i) |=> $stable(ser_o));
  // R5
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ser_o);
endmodule

// File: rtl/scif_regfile.sv
module scif_regfile
  import scif_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DAC_W  = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] status_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [RXG_W-1:0]  rx_gain_o,
  output logic [RXA_W-1:0]  rx_atten_o,
  output logic [TXA_W-1:0]  tx_atten_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DAC_W-1:0]  osc_dac_o,
  output logic [DATA_W-1:0] tone_thr_o,
  output logic [STAT_W-1:0] status_o
);
  logic [RXG_W-1:0]  rxg_q;
  logic [RXA_W-1:0]  rxa_q;
  logic [TXA_W-1:0]  txa_q;
  logic [DATA_W-1:0] cfg_q, tst0_q, tst1_q, thr_q;
  logic [DAC_W-1:0]  dac_q;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              stat_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxg_q  <= '0;
      rxa_q  <= '0;
      txa_q  <= '0;
      cfg_q  <= '0;
      dac_q  <= '0;
      tst0_q <= '0;
      tst1_q <= '0;
      thr_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_RXG: begin
          rxg_q <= data_i[RXG_W-1:0];
          rxa_q <= data_i[RXG_W+:RXA_W];
        end
        A_TXA:  txa_q  <= data_i[TXA_W-1:0];
        A_CFG:  cfg_q  <= data_i;
        A_DAC:  dac_q  <= data_i[DAC_W-1:0];
        A_TST0: tst0_q <= data_i;
        A_TST1: tst1_q <= data_i;
        A_THR:  thr_q  <= data_i;
        default: ;
      endcase
    end
  end

  assign stat_we = we_i && (addr_i == A_STAT);

  // set wins over a zero written in the same cycle
  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    assign stat_d[i] = status_set_i[i] | (stat_q[i] & ~(stat_we & ~data_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RXG:  rdata_o[RXG_W+RXA_W-1:0] = {rxa_q, rxg_q};
      A_TXA:  rdata_o[TXA_W-1:0]       = txa_q;
      A_CFG:  rdata_o                  = cfg_q;
      A_DAC:  rdata_o[DAC_W-1:0]       = dac_q;
      A_TST0: rdata_o                  = tst0_q;
      A_TST1: rdata_o                  = tst1_q;
      A_THR:  rdata_o                  = thr_q;
      default: rdata_o[STAT_W-1:0]     = stat_q;
    endcase
  end

  assign rx_gain_o  = rxg_q;
  assign rx_atten_o = rxa_q;
  assign tx_atten_o = txa_q;
  assign cfg_o      = cfg_q;
  assign osc_dac_o  = dac_q;
  assign tone_thr_o = thr_q;
  assign status_o   = stat_q;

  // R11
  stat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q)) & ~$past(status_set_i)) == '0);
endmodule

// File: rtl/scif_ctrl.sv
module scif_ctrl
  import scif_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DAC_W  = 8,
  parameter int STAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_i,
  input  logic              word_en_i,
  input  logic              ser_i,
  input  logic              rd_nwr_i,
  input  logic [STAT_W-1:0] status_set_i,
  output logic              ser_o,
  output logic [RXG_W-1:0]  rx_gain_o,
  output logic [RXA_W-1:0]  rx_atten_o,
  output logic [TXA_W-1:0]  tx_atten_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DAC_W-1:0]  osc_dac_o,
  output logic [DATA_W-1:0] tone_thr_o,
  output logic [STAT_W-1:0] status_o
);
  logic              commit, rd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  scif_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .suspend_i, .word_en_i, .ser_i, .rd_nwr_i,
    .commit_o(commit), .rd_o(rd), .addr_o(addr), .data_o(wdata)
  );

  scif_regfile #(.DATA_W(DATA_W), .DAC_W(DAC_W), .STAT_W(STAT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(commit && !rd), .addr_i(addr), .data_i(wdata),
    .status_set_i, .rdata_o(rdata),
    .rx_gain_o, .rx_atten_o, .tx_atten_o, .cfg_o, .osc_dac_o,
    .tone_thr_o, .status_o
  );

  scif_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .word_en_i,
    .load_i(commit && rd), .data_i(rdata), .ser_o
  );

  // R2
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !rd && addr != A_DAC) |=> $stable(osc_dac_o));
  // R6
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> $stable({rx_gain_o, rx_atten_o, tx_atten_o, cfg_o, osc_dac_o, tone_thr_o}));
endmodule

// File: tb/scif_ctrl_tb_top.sv
module scif_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni, suspend_i, word_en_i, ser_i, rd_nwr_i;
  logic [3:0]  status_set_i;
  logic        ser_o;
  logic [4:0]  rx_gain_o;
  logic [1:0]  rx_atten_o;
  logic [3:0]  tx_atten_o;
  logic [11:0] cfg_o, tone_thr_o;
  logic [7:0]  osc_dac_o;
  logic [3:0]  status_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [4:0]  m_rxg;
  logic [1:0]  m_rxa;
  logic [3:0]  m_txa, m_stat;
  logic [11:0] m_cfg, m_tst0, m_tst1, m_thr;
  logic [7:0]  m_dac;

  always #(CLK_PERIOD/2) clk = ~clk;

  scif_ctrl dut_i (
    .clk_i(clk), .rst_ni, .suspend_i, .word_en_i, .ser_i, .rd_nwr_i,
    .status_set_i, .ser_o, .rx_gain_o, .rx_atten_o, .tx_atten_o,
    .cfg_o, .osc_dac_o, .tone_thr_o, .status_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one qualified sample: word_en high for a single rising edge
  task automatic qbit(input logic b, input logic rw);
    @(negedge clk);
    ser_i = b; rd_nwr_i = rw; word_en_i = 1'b1;
    @(negedge clk);
    word_en_i = 1'b0; rd_nwr_i = ~rw;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic rw, input logic [2:0] a, input logic [11:0] d, input logic stop);
    logic [14:0] body;
    body = {d, a};
    qbit(1'b0, rw);
    for (int i = 14; i >= 0; i--) qbit(body[i], ~rw);
    qbit(stop, ~rw);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    send(1'b0, a, d, 1'b1);
  endtask

  function automatic logic [11:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {5'd0, m_rxa, m_rxg};
      3'd1: return {8'd0, m_txa};
      3'd2: return m_cfg;
      3'd3: return {4'd0, m_dac};
      3'd4: return m_tst0;
      3'd5: return m_tst1;
      3'd6: return m_thr;
      default: return {8'd0, m_stat};
    endcase
  endfunction

  task automatic rd_chk(input logic [2:0] a, input string tag);
    logic [11:0] v;
    v = '0;
    send(1'b1, a, 12'hA5A, 1'b1);
    check({tag, " start bit"}, ser_o, 1'b0);
    for (int i = 0; i < 12; i++) begin
      qbit(1'b1, 1'b1);
      v = {v[10:0], ser_o};
    end
    check(tag, v, exp_rd(a));
    qbit(1'b1, 1'b1);
    check({tag, " line idle"}, ser_o, 1'b1);
  endtask

  task automatic all_outs(input string tag);
    check({tag, " rx_gain"}, rx_gain_o, m_rxg);
    check({tag, " rx_atten"}, rx_atten_o, m_rxa);
    check({tag, " tx_atten"}, tx_atten_o, m_txa);
    check({tag, " cfg"}, cfg_o, m_cfg);
    check({tag, " dac"}, osc_dac_o, m_dac);
    check({tag, " thr"}, tone_thr_o, m_thr);
    check({tag, " status"}, status_o, m_stat);
  endtask

  task automatic model_clear();
    m_rxg = '0; m_rxa = '0; m_txa = '0; m_cfg = '0; m_tst0 = '0;
    m_tst1 = '0; m_thr = '0; m_dac = '0; m_stat = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; suspend_i = 1'b0; word_en_i = 1'b0; ser_i = 1'b1;
    rd_nwr_i = 1'b0; status_set_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    all_outs("R12 reset");
    check("R12 ser_o idle", ser_o, 1'b1);

    // R1 idle highs do nothing
    for (int i = 0; i < 20; i++) qbit(1'b1, 1'b0);
    all_outs("R1 idle line");

    // R7 R2 full sweep of receive gain and attenuator
    for (int a = 0; a < 4; a++)
      for (int g = 0; g < 32; g++) begin
        wr(3'd0, {5'h1F, a[1:0], g[4:0]});
        m_rxg = g[4:0]; m_rxa = a[1:0];
        check("R7 rx_gain", rx_gain_o, m_rxg);
        check("R7 rx_atten", rx_atten_o, m_rxa);
      end
    rd_chk(3'd0, "R7 readback");

    // R8 transmit sweep, R2 neighbours untouched
    for (int t = 0; t < 16; t++) begin
      wr(3'd1, {8'hFF, t[3:0]});
      m_txa = t[3:0];
      check("R8 tx_atten", tx_atten_o, m_txa);
      check("R2 rx_gain kept", rx_gain_o, m_rxg);
    end
    rd_chk(3'd1, "R8 readback");

    // R10 DAC low byte
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 5);
      wr(3'd3, {4'hF, v});
      m_dac = v;
      check("R10 dac", osc_dac_o, m_dac);
    end
    rd_chk(3'd3, "R10 readback");

    // R9 wide registers
    wr(3'd2, 12'hC35); m_cfg = 12'hC35;
    wr(3'd6, 12'h9E1); m_thr = 12'h9E1;
    wr(3'd4, 12'h5A3); m_tst0 = 12'h5A3;
    wr(3'd5, 12'hFFF); m_tst1 = 12'hFFF;
    all_outs("R9 R2 after wide writes");
    rd_chk(3'd2, "R9 cfg readback");
    rd_chk(3'd4, "R9 scratch0 readback");
    rd_chk(3'd5, "R9 scratch1 readback");
    rd_chk(3'd6, "R9 thr readback");

    // R13 update exactly at the stop edge
    begin
      logic [14:0] body;
      body = {12'h3C7, 3'd2};
      qbit(1'b0, 1'b0);
      for (int i = 14; i >= 0; i--) qbit(body[i], 1'b1);
      @(negedge clk);
      ser_i = 1'b1; word_en_i = 1'b1;
      check("R13 before stop edge", cfg_o, m_cfg);
      @(negedge clk);
      word_en_i = 1'b0;
      m_cfg = 12'h3C7;
      check("R13 after stop edge", cfg_o, m_cfg);
      repeat (2) @(negedge clk);
    end

    // R4 missing stop bit
    send(1'b0, 3'd2, 12'h0F0, 1'b0);
    qbit(1'b1, 1'b0);
    check("R4 no stop cfg", cfg_o, m_cfg);
    rd_chk(3'd2, "R4 cfg readback");

    // R3 R5 read frames leave registers as they were
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R5 R3 sweep read");
    all_outs("R5 after reads");

    // R6 suspend
    suspend_i = 1'b1;
    wr(3'd2, 12'h111);
    wr(3'd0, 12'h07F);
    send(1'b1, 3'd2, 12'h000, 1'b1);
    check("R6 no read reply", ser_o, 1'b1);
    suspend_i = 1'b0;
    all_outs("R6 suspended writes");
    wr(3'd2, 12'h222); m_cfg = 12'h222;
    check("R6 resumed write", cfg_o, m_cfg);

    // R11 status flags
    @(negedge clk); status_set_i = 4'b1011;
    @(negedge clk); status_set_i = 4'b0000;
    m_stat = 4'b1011;
    check("R11 set", status_o, m_stat);
    wr(3'd7, 12'hFF6);  // clear flags 0 and 3
    m_stat = 4'b0010;
    check("R11 clear on zero", status_o, m_stat);
    wr(3'd7, 12'h00F);
    check("R11 write one keeps", status_o, m_stat);
    status_set_i = 4'b0001;
    wr(3'd7, 12'h000);  // clears, but flag 0 is held set
    status_set_i = 4'b0000;
    m_stat = 4'b0001;
    check("R11 set wins", status_o, m_stat);
    rd_chk(3'd7, "R11 readback");

    // R12 asynchronous reset between edges, mid frame
    qbit(1'b0, 1'b0);
    qbit(1'b1, 1'b1);
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 model_clear();
    all_outs("R12 async reset");
    check("R12 ser_o", ser_o, 1'b1);
    @(negedge clk); rst_ni = 1'b1;
    wr(3'd6, 12'h0AB); m_thr = 12'h0AB;
    all_outs("R12 receiver idle after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule